// File: doc/BRIEF.md
# Serial Transmitter with Clear-to-Send Gating

This block turns bytes from a processor into asynchronous serial frames on a single output line. The processor places one byte into a single-entry holding buffer. The block moves that byte into a shift register and sends it as a frame. When the buffer frees up, the block raises a one-clock interrupt pulse so the next byte can be loaded. All bit timing comes from an enable tick that runs at sixteen times the bit rate. A free-running tick counter divides this tick into bit periods. The last tick of each period marks a bit boundary, which serves as the falling edge of the transmit bit clock.

When flow control is on, the active-low clear-to-send input decides whether a new frame may begin. The input passes through a two-stage synchroniser. It is looked at only at bit boundaries where a frame could start, so a frame already under way always finishes. A pending byte waits in the buffer, with the line held at mark, until clear-to-send is seen low at a boundary.

The controller has four states. IDLE holds the line high. START drives the low start bit. DATA drives the eight data bits. STOP drives the high stop bit. The transitions are:
- LAUNCH: from IDLE, or from STOP at its final boundary, to START. It needs a bit boundary, a full buffer, and either gating off or synchronised clear-to-send low.
- FIRST_BIT: from START to DATA at the next boundary.
- NEXT_BIT: from DATA back to DATA at each boundary until the eighth bit.
- LAST_BIT: from DATA to STOP after the eighth bit.
- RETIRE: from STOP to IDLE at its boundary when LAUNCH does not apply.

Top module: `uart_cts_tx`

## Requirements
- R1: A synchronous reset leaves the line high, the buffer empty (`buf_empty_o`=1), the interrupt low and the tick counter at 1.
- R2: A write while `buf_empty_o`=1 stores the byte and clears `buf_empty_o` on the next clock. A write while `buf_empty_o`=0 is ignored, and the byte already held is the one sent.
- R3: A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. Each bit lasts exactly 16 ticks.
- R4: The tick counter runs 1 to 16 and wraps from 16 back to 1. The line changes only in the clock after a tick taken while the counter reads 16, which is a bit boundary.
- R5: With gating on (`cts_en_i`=1) and synchronised clear-to-send high, no frame starts. The line stays high and the buffer stays full.
- R6: With gating off (`cts_en_i`=0), `cts_n_i` has no effect, and a buffered byte starts at the next bit boundary.
- R7: If clear-to-send goes high during a frame, that frame is still sent in full.
- R8: Once synchronised clear-to-send is low, a pending byte starts at the first following bit boundary.
- R9: When a byte moves from the buffer into the shift register, `buf_empty_o` goes to 1. In the same clock `irq_o` pulses high for exactly one clock if `irq_en_i` was 1, and stays low otherwise.
- R10: A byte already in the buffer when a stop bit ends starts at that same boundary, with no idle bit between the frames.
- R11: `cts_n_i` reaches the gating logic through two clocked stages, so a change affects the launch decision two clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Oversampling enable, sixteen per bit |
| cts_en_i | input | 1 | Flow-control gating enable |
| irq_en_i | input | 1 | Buffer-empty interrupt enable |
| cts_n_i | input | 1 | Clear-to-send, active low, asynchronous |
| wr_i | input | 1 | Buffer write strobe |
| wr_data_i | input | 8 | Byte to write |
| txd_o | output | 1 | Serial line, idle high |
| irq_o | output | 1 | One-clock buffer-empty interrupt pulse |
| buf_empty_o | output | 1 | Holding buffer empty flag |

## Verification
The bench drives the block with several patterns:
- Single bytes with gating off and clear-to-send held high show that the input is ignored and fix the frame layout.
- A second write while the buffer is full separates accepting the write from dropping it.
- Writing a byte during a frame exposes any idle bit slipped between back-to-back frames.
- With gating on, a byte left pending while clear-to-send is high shows whether the block holds off, and releasing the input shows where the start bit lands.
- Raising clear-to-send partway through a frame, and running a phase with the interrupt disabled, separate mid-frame aborts and stray pulses from correct behaviour.

// File: rtl/uart_cts_tx_pkg.sv
package uart_cts_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;

endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= async_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/tx_tick_counter.sv
module tx_tick_counter #(
    parameter int OVERSAMPLE = 16,
    localparam int CW = $clog2(OVERSAMPLE + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    output logic [CW-1:0] cnt_o,
    output logic          bit_end_o
);
    localparam logic [CW-1:0] LAST  = CW'(OVERSAMPLE);
    localparam logic [CW-1:0] FIRST = CW'(1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= FIRST;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == LAST) ? FIRST : cnt_q + FIRST;
        end
    end

    assign cnt_o     = cnt_q;
    assign bit_end_o = tick_i && (cnt_q == LAST);
endmodule

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              take_i,
    input  logic              irq_en_i,
    output logic [DATA_W-1:0] data_o,
    output logic              empty_o,
    output logic              irq_o
);
    logic [DATA_W-1:0] data_q;
    logic              empty_q;
    logic              irq_q;
    logic              accept;

    assign accept = wr_i && empty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            empty_q <= 1'b1;
            irq_q   <= 1'b0;
        end else begin
            if (accept) data_q <= wr_data_i;
            if (take_i)      empty_q <= 1'b1;
            else if (accept) empty_q <= 1'b0;
            irq_q <= take_i && !empty_q && irq_en_i;
        end
    end

    assign data_o  = data_q;
    assign empty_o = empty_q;
    assign irq_o   = irq_q;
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
    import uart_cts_tx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              cts_en_i,
    input  logic              irq_en_i,
    input  logic              cts_n_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              txd_o,
    output logic              irq_o,
    output logic              buf_empty_o
);
    localparam int CW = $clog2(OVERSAMPLE + 1);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    tx_state_e         state_q, state_d;
    logic [CW-1:0]     cnt;
    logic              bit_end;
    logic              cts_s;
    logic [DATA_W-1:0] hold_data;
    logic [DATA_W-1:0] shift_q;
    logic [BW-1:0]     bidx_q;
    logic              clear_ok;
    logic              launch;

    cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (cts_n_i),
        .sync_o  (cts_s)
    );

    tx_tick_counter #(.OVERSAMPLE(OVERSAMPLE)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .cnt_o     (cnt),
        .bit_end_o (bit_end)
    );

    tx_hold_buf #(.DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (wr_i),
        .wr_data_i (wr_data_i),
        .take_i    (launch),
        .irq_en_i  (irq_en_i),
        .data_o    (hold_data),
        .empty_o   (buf_empty_o),
        .irq_o     (irq_o)
    );

    assign clear_ok = !cts_en_i || !cts_s;

    // next-state logic
    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (bit_end && !buf_empty_o && clear_ok) begin
                    launch  = 1'b1;
                    state_d = ST_START;
                end
            end
            ST_START: begin
                if (bit_end) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (bit_end && bidx_q == LAST_BIT) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (bit_end) begin
                    if (!buf_empty_o && clear_ok) begin
                        launch  = 1'b1;
                        state_d = ST_START;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            shift_q <= '0;
            bidx_q  <= '0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                shift_q <= hold_data;
                bidx_q  <= '0;
            end else if (state_q == ST_DATA && bit_end && bidx_q != LAST_BIT) begin
                shift_q <= shift_q >> 1;
                bidx_q  <= bidx_q + BW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_START: txd_o = 1'b0;
            ST_DATA:  txd_o = shift_q[0];
            default:  txd_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_cts_tx_chk.sv
module uart_cts_tx_chk
    import uart_cts_tx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    localparam int CW = $clog2(OVERSAMPLE + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          cts_en_i,
    input logic          irq_en_i,
    input logic          wr_i,
    input logic          txd_o,
    input logic          irq_o,
    input logic          buf_empty_o,
    input logic [CW-1:0] cnt,
    input logic          bit_end,
    input logic          cts_s,
    input tx_state_e     state_q
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (txd_o && buf_empty_o && !irq_o && cnt == CW'(1)));

    // R4
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt >= CW'(1)) && (cnt <= CW'(OVERSAMPLE)));

    // R4
    line_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(txd_o) |-> $past(bit_end));

    // R5
    hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && cts_en_i && cts_s) |=> txd_o);

    // R2
    empty_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(buf_empty_o) |-> $past(wr_i));

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (buf_empty_o && $past(!buf_empty_o) && $past(irq_en_i)));

    // R9
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);
endmodule

bind uart_cts_tx uart_cts_tx_chk #(.OVERSAMPLE(OVERSAMPLE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cts_en_i    (cts_en_i),
    .irq_en_i    (irq_en_i),
    .wr_i        (wr_i),
    .txd_o       (txd_o),
    .irq_o       (irq_o),
    .buf_empty_o (buf_empty_o),
    .cnt         (cnt),
    .bit_end     (bit_end),
    .cts_s       (cts_s),
    .state_q     (state_q)
);

// File: tb/tb_uart_cts_tx.sv
module tb_uart_cts_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       cts_en_i = 1'b0;
    logic       irq_en_i = 1'b1;
    logic       cts_n_i = 1'b1;
    logic       wr_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       txd_o, irq_o, buf_empty_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int irq_seen = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_cts_tx dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .cts_en_i(cts_en_i),
        .irq_en_i(irq_en_i), .cts_n_i(cts_n_i), .wr_i(wr_i),
        .wr_data_i(wr_data_i), .txd_o(txd_o), .irq_o(irq_o),
        .buf_empty_o(buf_empty_o)
    );

    // tick every second clock
    always @(negedge clk) tick_i <= ~tick_i;

    // behavioural reference model
    int   m_cnt = 1;
    bit   m_s1 = 1, m_s2 = 1;
    int   m_st = 0;          // 0 idle, 1 start, 2 data, 3 stop
    int   m_bit = 0;
    bit   m_empty = 1;
    bit   m_irq = 0;
    byte  m_hold = 0;
    byte  m_sh = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 1; m_s1 = 1; m_s2 = 1; m_st = 0; m_bit = 0;
            m_empty = 1; m_irq = 0; m_hold = 0; m_sh = 0;
        end else begin
            bit bnd, go, acc;
            bnd = tick_i && (m_cnt == 16);
            go  = bnd && (m_st == 0 || m_st == 3) && !m_empty && (!cts_en_i || !m_s2);
            acc = wr_i && m_empty;
            if (go) begin
                m_st = 1; m_sh = m_hold; m_bit = 0;
            end else if (bnd) begin
                case (m_st)
                    1: m_st = 2;
                    2: if (m_bit == 7) m_st = 3;
                       else begin m_bit++; m_sh = byte'(8'(m_sh) >> 1); end
                    3: m_st = 0;
                    default: ;
                endcase
            end
            m_irq = go && irq_en_i;
            if (go) m_empty = 1;
            else if (acc) m_empty = 0;
            if (acc) m_hold = wr_data_i;
            if (tick_i) m_cnt = (m_cnt == 16) ? 1 : m_cnt + 1;
            m_s2 = m_s1;
            m_s1 = cts_n_i;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (!rst && !done) begin
            bit exp_txd;
            exp_txd = (m_st == 1) ? 1'b0 : (m_st == 2) ? m_sh[0] : 1'b1;
            check(txd_o == exp_txd, "R3 line vs model", txd_o, exp_txd);
            check(buf_empty_o == m_empty, "R2 buffer flag vs model", buf_empty_o, m_empty);
            check(irq_o == m_irq, "R9 interrupt vs model", irq_o, m_irq);
            if (irq_o) irq_seen++;
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk); wr_i = 1'b1; wr_data_i = b;
        @(negedge clk); wr_i = 1'b0;
    endtask

    task automatic wait_start();
        int n = 0;
        while (txd_o && n < 4000) begin @(negedge clk); n++; end
    endtask

    initial begin
        int irq_before;
        idle(3);
        // R1 reset state
        check(txd_o == 1'b1, "R1 line high in reset", txd_o, 1);
        check(buf_empty_o == 1'b1, "R1 buffer empty in reset", buf_empty_o, 1);
        check(irq_o == 1'b0, "R1 no interrupt in reset", irq_o, 0);
        rst = 1'b0;
        idle(5);
        check(txd_o == 1'b1, "R1 line idle after reset", txd_o, 1);

        // R6 gating off, cts high ignored; R3 frame layout
        cts_n_i = 1'b1;
        put(8'hA5);
        check(buf_empty_o == 1'b0, "R2 write captured", buf_empty_o, 0);
        idle(400);
        check(txd_o == 1'b1, "R6 frame sent with cts high and gating off", txd_o, 1);
        check(buf_empty_o == 1'b1, "R6 buffer drained", buf_empty_o, 1);

        // R2 write while full is dropped
        put(8'h3C);
        put(8'hFF);
        check(buf_empty_o == 1'b0, "R2 buffer still full", buf_empty_o, 0);
        idle(400);

        // R10 back-to-back frames
        put(8'h81);
        wait_start();
        idle(4);
        put(8'h5A);
        idle(700);
        check(buf_empty_o == 1'b1, "R10 both frames drained", buf_empty_o, 1);

        // R5 gating on, cts high holds off
        cts_en_i = 1'b1;
        cts_n_i  = 1'b1;
        put(8'hC3);
        idle(1000);
        check(txd_o == 1'b1, "R5 line held at mark", txd_o, 1);
        check(buf_empty_o == 1'b0, "R5 byte still pending", buf_empty_o, 0);

        // R11/R8 release cts, start at first boundary after sync
        cts_n_i = 1'b0;
        idle(1);
        check(txd_o == 1'b1, "R11 no start before synchroniser", txd_o, 1);
        idle(400);
        check(buf_empty_o == 1'b1, "R8 pending byte sent", buf_empty_o, 1);

        // R7 cts rises mid-frame
        put(8'h96);
        wait_start();
        idle(60);
        cts_n_i = 1'b1;
        put(8'h0F);
        idle(900);
        check(txd_o == 1'b1, "R7 next frame held after completed one", txd_o, 1);
        check(buf_empty_o == 1'b0, "R7 next byte waits", buf_empty_o, 0);
        cts_n_i = 1'b0;
        idle(400);

        // R9 interrupt disabled
        irq_en_i = 1'b0;
        irq_before = irq_seen;
        put(8'h44);
        idle(400);
        check(irq_seen == irq_before, "R9 no pulse when disabled", irq_seen, irq_before);
        check(irq_seen == 7, "R9 pulse count", irq_seen, 7);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule